// File: doc/BRIEF.md
# Offset Trim Calibration Controller

This block finds an output offset trim code for one converter channel without software help. A start request takes the channel out of service: the channel enable is forced low, the channel's mode field is forced to zero, and the calibration enable output is raised. The controller then runs a binary search over the trim range. For each step it drives a candidate code, waits a fixed settling interval, and then reads a single comparator flag. A high flag means the candidate is too large, so the next candidate is smaller. A low flag means the next candidate is larger.

After the last halving step, the controller applies the final candidate and lets it settle once more. It then applies a one-code correction, writes the result to the held trim, returns the channel enable and mode to their configured values, and emits a one-cycle done pulse. While the block is idle, software can also load a trim code directly. Such a load marks the trim as user-sourced.

Top module: `trim_cal_top`

## Requirements
- R1: After reset, trimOut is 0, trimUser is 0, busy, done, calEn and errPulse are 0, and chanEnOut and modeOut follow chanEnCfg and modeCfg.
- R2: A one-cycle startReq while idle and with chanBusy low raises busy and calEn from the next cycle until the run ends. During the run, chanEnOut and modeOut are forced to 0.
- R3: startReq while chanBusy is high starts no run and gives a one-cycle errPulse in the next cycle. trimOut and trimUser keep their values.
- R4: The first candidate driven on trimOut is 0x10. Four halving steps follow, with step sizes 8, 4, 2 and 1. A high cmpFlag at the sample point lowers the candidate by the step size; a low flag raises it by the step size.
- R5: Each candidate, including the final one, is held for SETTLE_CYC = CYC_PER_US*SETTLE_US clock cycles before the flag is sampled. A run therefore keeps busy high for exactly 5*SETTLE_CYC cycles.
- R6: At the final sample, a low cmpFlag with a candidate below 0x1F stores the candidate plus one. In every other case the candidate itself is stored.
- R7: done is a single-cycle pulse in the first cycle with busy low after a run. From that cycle, calEn is 0, chanEnOut and modeOut follow their configuration inputs again, trimOut shows the result, and trimUser is 0.
- R8: userWrEn while idle loads userTrim onto trimOut in the next cycle and sets trimUser to 1.
- R9: userWrEn and startReq during a run are ignored. The run's result and trimUser = 0 are what remain, and no errPulse occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Request a calibration run |
| chanBusy | input | 1 | Channel currently in use; a start is refused |
| cmpFlag | input | 1 | Comparator result, high when the offset is too high |
| chanEnCfg | input | 1 | Configured channel enable |
| modeCfg | input | MODE_W | Configured channel mode |
| userWrEn | input | 1 | Direct trim write strobe |
| userTrim | input | TRIM_W | Direct trim value |
| chanEnOut | output | 1 | Effective channel enable |
| modeOut | output | MODE_W | Effective channel mode |
| calEn | output | 1 | Calibration enable to the analog stage |
| trimOut | output | TRIM_W | Trim code applied to the channel |
| trimUser | output | 1 | Held trim came from a direct write |
| busy | output | 1 | Calibration in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| errPulse | output | 1 | One-cycle refused-start pulse |

## Verification
The corner that is hardest to reach from the ports is the final correction at the top of the range. There the search ends on 0x1F with the flag still low, and the increment must be suppressed. The bench reaches this corner with a comparator model whose threshold lies above every code, and it reaches the opposite corner with a threshold of zero. Random thresholds across the whole range fill the interior. Inside some runs the bench injects direct writes and repeated start requests, to show that the run's result wins over them.

// File: rtl/trim_cal_pkg.sv
package trim_cal_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SEARCH = 2'd1,
    ST_FINAL  = 2'd2
  } calState_t;

  typedef struct packed {
    logic initSearch;
    logic stepSearch;
    logic finish;
    logic userLoad;
  } ctrlStrobes_t;
endpackage

// File: rtl/trim_cal_ctrl.sv
module trim_cal_ctrl
  import trim_cal_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         startReq,
  input  logic         chanBusy,
  input  logic         userWrEn,
  input  logic         settleDone,
  input  logic         deltaLast,
  output ctrlStrobes_t strb,
  output logic         busy,
  output logic         done,
  output logic         errPulse
);
  calState_t state, stateNext;

  always_comb begin
    stateNext = state;
    strb = '0;
    unique case (state)
      ST_IDLE: begin
        if (startReq && !chanBusy) begin
          strb.initSearch = 1'b1;
          stateNext = ST_SEARCH;
        end else if (userWrEn && !startReq) begin
          strb.userLoad = 1'b1;
        end
      end
      ST_SEARCH: begin
        if (settleDone) begin
          strb.stepSearch = 1'b1;
          if (deltaLast) stateNext = ST_FINAL;
        end
      end
      ST_FINAL: begin
        if (settleDone) begin
          strb.finish = 1'b1;
          stateNext = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      done     <= 1'b0;
      errPulse <= 1'b0;
    end else begin
      state    <= stateNext;
      done     <= strb.finish;
      errPulse <= (state == ST_IDLE) && startReq && chanBusy;
    end
  end

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/trim_cal_dp.sv
module trim_cal_dp
  import trim_cal_pkg::*;
#(
  parameter int TRIM_W     = 5,
  parameter int SETTLE_CYC = 100
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strb,
  input  logic              busy,
  input  logic              cmpFlag,
  input  logic [TRIM_W-1:0] userTrim,
  output logic [TRIM_W-1:0] trimOut,
  output logic              trimUser,
  output logic              settleDone,
  output logic              deltaLast
);
  localparam int CNT_W = $clog2(SETTLE_CYC + 1);
  localparam logic [CNT_W-1:0]  LOAD_V  = CNT_W'(SETTLE_CYC - 1);
  localparam logic [TRIM_W-1:0] CAND0   = TRIM_W'(1) << (TRIM_W - 1);
  localparam logic [TRIM_W-1:0] DELTA0  = TRIM_W'(1) << (TRIM_W - 2);
  localparam logic [TRIM_W-1:0] TRIM_MX = '1;

  logic [TRIM_W-1:0] cand, delta, trimReg;
  logic [CNT_W-1:0]  settleCnt;

  assign settleDone = (settleCnt == '0);
  assign deltaLast  = (delta == TRIM_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      settleCnt <= '0;
    end else if (strb.initSearch || (strb.stepSearch)) begin
      settleCnt <= LOAD_V;
    end else if (!settleDone) begin
      settleCnt <= settleCnt - CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cand  <= CAND0;
      delta <= DELTA0;
    end else if (strb.initSearch) begin
      cand  <= CAND0;
      delta <= DELTA0;
    end else if (strb.stepSearch) begin
      cand  <= cmpFlag ? (cand - delta) : (cand + delta);
      delta <= delta >> 1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      trimReg  <= '0;
      trimUser <= 1'b0;
    end else if (strb.finish) begin
      trimReg  <= (!cmpFlag && cand != TRIM_MX) ? cand + TRIM_W'(1) : cand;
      trimUser <= 1'b0;
    end else if (strb.userLoad) begin
      trimReg  <= userTrim;
      trimUser <= 1'b1;
    end
  end

  assign trimOut = busy ? cand : trimReg;
endmodule

// File: rtl/trim_cal_top.sv
module trim_cal_top
  import trim_cal_pkg::*;
#(
  parameter int TRIM_W    = 5,
  parameter int MODE_W    = 3,
  parameter int CYC_PER_US = 2,
  parameter int SETTLE_US = 50
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic              chanBusy,
  input  logic              cmpFlag,
  input  logic              chanEnCfg,
  input  logic [MODE_W-1:0] modeCfg,
  input  logic              userWrEn,
  input  logic [TRIM_W-1:0] userTrim,
  output logic              chanEnOut,
  output logic [MODE_W-1:0] modeOut,
  output logic              calEn,
  output logic [TRIM_W-1:0] trimOut,
  output logic              trimUser,
  output logic              busy,
  output logic              done,
  output logic              errPulse
);
  localparam int SETTLE_CYC = CYC_PER_US * SETTLE_US;

  ctrlStrobes_t strb;
  logic settleDone, deltaLast;

  trim_cal_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .startReq(startReq), .chanBusy(chanBusy),
    .userWrEn(userWrEn), .settleDone(settleDone), .deltaLast(deltaLast),
    .strb(strb), .busy(busy), .done(done), .errPulse(errPulse)
  );

  trim_cal_dp #(.TRIM_W(TRIM_W), .SETTLE_CYC(SETTLE_CYC)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .busy(busy), .cmpFlag(cmpFlag),
    .userTrim(userTrim), .trimOut(trimOut), .trimUser(trimUser),
    .settleDone(settleDone), .deltaLast(deltaLast)
  );

  assign calEn     = busy;
  assign chanEnOut = busy ? 1'b0 : chanEnCfg;
  assign modeOut   = busy ? '0 : modeCfg;
endmodule

// File: rtl/trim_cal_chk.sv
module trim_cal_chk #(
  parameter int TRIM_W = 5,
  parameter int MODE_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              done,
  input logic              calEn,
  input logic              chanEnOut,
  input logic [MODE_W-1:0] modeOut,
  input logic [TRIM_W-1:0] trimOut,
  input logic              trimUser,
  input logic              errPulse
);
  // R2
  run_isolates_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (calEn && !chanEnOut && modeOut == '0));
  // R4
  first_cand_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> (trimOut == (TRIM_W'(1) << (TRIM_W - 1))));
  // R7
  done_on_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && !calEn && !trimUser));
  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R3
  err_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |-> !busy);
  // R9
  no_err_in_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> !errPulse);
endmodule

bind trim_cal_top trim_cal_chk #(.TRIM_W(TRIM_W), .MODE_W(MODE_W)) chk_i (
  .clk(clk), .rstN(rstN), .busy(busy), .done(done), .calEn(calEn),
  .chanEnOut(chanEnOut), .modeOut(modeOut), .trimOut(trimOut),
  .trimUser(trimUser), .errPulse(errPulse)
);

// File: tb/trim_cal_top_tb_top.sv
module trim_cal_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TRIM_W = 5;
  localparam int MODE_W = 3;
  localparam int SETTLE_CYC = 2 * 50;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0, chanBusy = 1'b0, chanEnCfg = 1'b1, userWrEn = 1'b0;
  logic [MODE_W-1:0] modeCfg = 3'd5;
  logic [TRIM_W-1:0] userTrim = '0;
  logic cmpFlag;
  logic chanEnOut, calEn, trimUser, busy, done, errPulse;
  logic [MODE_W-1:0] modeOut;
  logic [TRIM_W-1:0] trimOut;
  int target = 0;
  int nChecks = 0, nErrs = 0;
  int errSeen = 0, doneSeen = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // comparator model: offset too high when code reaches the threshold
  assign cmpFlag = (int'(trimOut) >= target);

  trim_cal_top dut_i (
    .clk(clk), .rstN(rstN), .startReq(startReq), .chanBusy(chanBusy),
    .cmpFlag(cmpFlag), .chanEnCfg(chanEnCfg), .modeCfg(modeCfg),
    .userWrEn(userWrEn), .userTrim(userTrim), .chanEnOut(chanEnOut),
    .modeOut(modeOut), .calEn(calEn), .trimOut(trimOut), .trimUser(trimUser),
    .busy(busy), .done(done), .errPulse(errPulse)
  );

  always @(posedge clk) begin
    if (errPulse) errSeen++;
    if (done) doneSeen++;
  end

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErrs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expTrim(input int thr);
    int c = 16;
    int d = 8;
    for (int i = 0; i < 4; i++) begin
      if (c >= thr) c -= d; else c += d;
      d = d / 2;
    end
    if (!(c >= thr) && c < 31) c++;
    return c;
  endfunction

  task automatic runCal(input int thr, input bit disturb);
    int cyc = 0;
    int e0, d0;
    target = thr;
    e0 = errSeen;
    d0 = doneSeen;
    @(negedge clk);
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    check("R2 busy", busy, 1);
    check("R2 isolate", {calEn, chanEnOut, modeOut == 0}, 3'b101);
    check("R4 first cand", trimOut, 16);
    while (busy && cyc < 2000) begin
      cyc++;
      if (disturb && cyc == 30) begin userWrEn = 1'b1; userTrim = 5'd3; startReq = 1'b1; end
      if (disturb && cyc == 31) begin userWrEn = 1'b0; startReq = 1'b0; end
      @(negedge clk);
    end
    check("R5 run length", cyc, 5 * SETTLE_CYC);
    check("R7 done pulse", done, 1);
    check("R6 result", trimOut, expTrim(thr));
    check("R7 restore", {calEn, chanEnOut, modeOut, trimUser}, {1'b0, chanEnCfg, modeCfg, 1'b0});
    @(negedge clk);
    check("R7 single done", doneSeen - d0, 1);
    if (disturb) check("R9 no err", errSeen - e0, 0);
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check("R1 trim", trimOut, 0);
    check("R1 flags", {busy, done, calEn, errPulse, trimUser}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 pass-through", {chanEnOut, modeOut}, {chanEnCfg, modeCfg});

    // R8 direct write
    userTrim = 5'd21; userWrEn = 1'b1;
    @(negedge clk);
    userWrEn = 1'b0;
    check("R8 trim", trimOut, 21);
    check("R8 user flag", trimUser, 1);

    // R3 refused start
    chanBusy = 1'b1; startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0; chanBusy = 1'b0;
    check("R3 err", errPulse, 1);
    check("R3 no run", busy, 0);
    check("R3 trim kept", {trimOut, trimUser}, {5'd21, 1'b1});
    @(negedge clk);
    check("R3 err single", errPulse, 0);

    // directed corners: R6 top suppression and bottom end
    runCal(32, 1'b0);
    runCal(0, 1'b0);
    runCal(31, 1'b0);
    runCal(16, 1'b1);  // R9 disturbance during run

    for (int k = 0; k < 10; k++) begin
      modeCfg = 3'($urandom_range(7));
      chanEnCfg = 1'($urandom_range(1));
      runCal(int'($urandom_range(32)), 1'($urandom_range(1)));
    end

    userTrim = 5'd7; userWrEn = 1'b1;
    @(negedge clk);
    userWrEn = 1'b0;
    check("R8 after cal", {trimOut, trimUser}, {5'd7, 1'b1});

    $display("Result: errors=%0d of %0d checks", nErrs, nChecks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    nErrs++;
    nChecks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", nErrs, nChecks);
    $finish;
  end
endmodule